// File: doc/BRIEF.md
# Data-Link Receive Interrupt Status Controller

This block turns single-cycle event pulses from a receive data-link controller into sticky status bits and a single level-sensitive interrupt request for a microprocessor. Three sources are tracked: a message has started arriving, a message has finished arriving, and an abort sequence was seen on the link channel. Each status bit stays set after its event until software services it, so no event is missed between polls.

Two layers of masking decide whether a latched bit reaches the interrupt line. Each source has its own enable bit, and one group enable covers the whole data-link source group. Software reaches the enables, the status and a clear-mode control through a small register port with one address per register. The clear-mode bit picks how status is serviced for all sources together: either reading the status register clears what was returned, or software writes ones to the bits it wants to clear.

Top module: `dl_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all status bits, all source enables and the group enable, selects write-one-to-clear mode, and drives `irq` and `rdata` to 0.
- R2: A pulse on `evt` bit 0 (message start), bit 1 (message end) or bit 2 (abort) sets status bit 0, 1 or 2 respectively, and the bit stays set until it is cleared.
- R3: Status bits latch events regardless of the enable settings; enables only mask `irq`.
- R4: With control register (address 3) bit 0 set to 1, a read of the status register (address 2) returns the status and clears exactly the bits it returned at the same clock edge.
- R5: With control bit 0 at 0, writing the status register clears each bit where `wdata` holds 1 and leaves bits where it holds 0; in clear-on-read mode a write to the status register has no effect.
- R6: An event in the same cycle as a clear of its bit leaves the bit set.
- R7: `irq` is high whenever the group enable is 1 and at least one status bit has its source enable (address 1, bit per source) set; it follows the registers with no extra delay.
- R8: Reads return register contents one cycle after `rd_en`: address 0 bit 0 is the group enable, address 1 holds the source enables, address 3 bit 0 the clear mode; unused bits read 0.
- R9: While the group enable (address 0 bit 0) is 0, `irq` stays low whatever the status and source enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | NUM_SRC | Event pulses: bit 0 start, bit 1 end, bit 2 abort |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives single and multiple simultaneous event pulses with all enables off, then with only the source enables, then with both levels, which separates latching from masking and shows the group enable dominating. It services status in both clear modes, with write patterns mixing ones and zeros, to tell a selective clear from a blanket one and to show the mode switch really disables the other path. Events placed on the exact edge of a write clear and of a clearing read show whether the new event survives and whether the read returned the old value.

// File: rtl/dl_irq_pkg.sv
package dl_irq_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_GRP_EN  = 2'd0,
      REG_SRC_EN  = 2'd1,
      REG_STATUS  = 2'd2,
      REG_CONTROL = 2'd3
   } reg_sel_e;

   typedef enum logic {
      CLR_W1C   = 1'b0,
      CLR_ON_RD = 1'b1
   } clr_mode_e;
endpackage

// File: rtl/dl_irq_status_bit.sv
module dl_irq_status_bit (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic stat_o
);
   always_ff @(posedge clk) begin
      if (rst)        stat_o <= 1'b0;
      else if (set_i) stat_o <= 1'b1;
      else if (clr_i) stat_o <= 1'b0;
   end

   a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
      stat_o && !clr_i |=> stat_o);
   a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
      set_i |=> stat_o);
   a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
      clr_i && !set_i |=> !stat_o);
endmodule

// File: rtl/dl_irq_regs.sv
module dl_irq_regs
   import dl_irq_pkg::*;
#(
   parameter int NUM_SRC = 3,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] status_i,
   output logic               grp_en_o,
   output logic [NUM_SRC-1:0] src_en_o,
   output clr_mode_e          mode_o,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [DATA_W-1:0]  rdata_o
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_width
         $error("NUM_SRC must lie between 1 and DATA_W");
      end
   endgenerate

   logic              hit_status;
   logic [DATA_W-1:0] rd_next;

   assign hit_status = (addr == REG_STATUS);

   always_ff @(posedge clk) begin
      if (rst) begin
         grp_en_o <= 1'b0;
         src_en_o <= '0;
         mode_o   <= CLR_W1C;
      end else if (wr_en) begin
         case (addr)
            REG_GRP_EN:  grp_en_o <= wdata[0];
            REG_SRC_EN:  src_en_o <= wdata[NUM_SRC-1:0];
            REG_CONTROL: mode_o   <= clr_mode_e'(wdata[0]);
            default: ;
         endcase
      end
   end

   always_comb begin
      clr_o = '0;
      if (mode_o == CLR_W1C && wr_en && hit_status)
         clr_o = wdata[NUM_SRC-1:0];
      else if (mode_o == CLR_ON_RD && rd_en && hit_status)
         clr_o = status_i;
   end

   always_comb begin
      rd_next = '0;
      case (addr)
         REG_GRP_EN:  rd_next[0]         = grp_en_o;
         REG_SRC_EN:  rd_next[NUM_SRC-1:0] = src_en_o;
         REG_STATUS:  rd_next[NUM_SRC-1:0] = status_i;
         REG_CONTROL: rd_next[0]         = mode_o;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)        rdata_o <= '0;
      else if (rd_en) rdata_o <= rd_next;
   end

   a_r5_no_clear_from_write_in_cor: assert property (@(posedge clk) disable iff (rst)
      mode_o == CLR_ON_RD && !rd_en |-> clr_o == '0);
endmodule

// File: rtl/dl_irq_combine.sv
module dl_irq_combine #(
   parameter int NUM_SRC = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] status_i,
   input  logic [NUM_SRC-1:0] src_en_i,
   input  logic               grp_en_i,
   output logic               irq_o
);
   logic [NUM_SRC-1:0] qual;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
         assign qual[i] = status_i[i] & src_en_i[i];
      end
   endgenerate

   assign irq_o = grp_en_i & (|qual);

   a_r9_group_mask: assert property (@(posedge clk) disable iff (rst)
      !grp_en_i |-> !irq_o);
   a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
      irq_o |-> status_i != '0);
endmodule

// File: rtl/dl_irq_ctrl.sv
module dl_irq_ctrl
   import dl_irq_pkg::*;
#(
   parameter int NUM_SRC = 3,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic               irq
);
   logic [NUM_SRC-1:0] status_q;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] src_en;
   logic               grp_en;
   clr_mode_e          mode;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
         dl_irq_status_bit u_bit (
            .clk    (clk),
            .rst    (rst),
            .set_i  (evt[i]),
            .clr_i  (clr_vec[i]),
            .stat_o (status_q[i])
         );
      end
   endgenerate

   dl_irq_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .status_i (status_q),
      .grp_en_o (grp_en),
      .src_en_o (src_en),
      .mode_o   (mode),
      .clr_o    (clr_vec),
      .rdata_o  (rdata)
   );

   dl_irq_combine #(.NUM_SRC(NUM_SRC)) u_comb (
      .clk      (clk),
      .rst      (rst),
      .status_i (status_q),
      .src_en_i (src_en),
      .grp_en_i (grp_en),
      .irq_o    (irq)
   );

   a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
      mode == CLR_ON_RD && rd_en && addr == REG_STATUS && evt == '0 |=> status_q == '0);
   a_r3_latch_unmasked: assert property (@(posedge clk) disable iff (rst)
      evt != '0 |=> status_q != '0);
endmodule

// File: tb/dl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dl_irq_ctrl_bench;
   localparam int NS = 3;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NS-1:0] evt = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [1:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   bit pend = 0;

   typedef struct { logic [DW-1:0] exp; string tag; } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   dl_irq_ctrl #(.NUM_SRC(NS), .DATA_W(DW)) u_dl_irq_ctrl (
      .clk(clk), .rst(rst), .evt(evt), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   always @(posedge clk) pend <= rd_en;

   // monitor: compares read data one cycle after the strobe
   always @(negedge clk) begin
      if (pend && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         n_chk++;
         if (rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; evt = '0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [DW-1:0] e, input string tag);
      item_t it;
      it.exp = e; it.tag = tag;
      sb.push_back(it);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0; evt = '0;
      @(negedge clk);
   endtask

   task automatic pulse(input logic [NS-1:0] v);
      evt = v;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      n_chk++;
      if (irq !== e) begin
         n_fail++;
         $display("FAIL %s: irq=%b expected=%b", tag, irq, e);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk_irq(1'b0, "R1 irq after reset");
      rd(2'd2, 8'h00, "R1 status after reset");
      rd(2'd3, 8'h00, "R1 mode after reset");
      rd(2'd1, 8'h00, "R1 source enables after reset");
      rd(2'd0, 8'h00, "R1 group enable after reset");

      pulse(3'b001);
      rd(2'd2, 8'h01, "R2 start event latched");
      rd(2'd2, 8'h01, "R2 status sticky across read in w1c mode");
      chk_irq(1'b0, "R3 latched but masked");
      pulse(3'b110);
      rd(2'd2, 8'h07, "R2 end and abort latched");

      wr(2'd2, 8'h02);
      rd(2'd2, 8'h05, "R5 w1c clears only written ones");
      wr(2'd2, 8'h00);
      rd(2'd2, 8'h05, "R5 w1c zeros leave bits");

      wr(2'd1, 8'h04);
      chk_irq(1'b0, "R9 group enable off masks all");
      wr(2'd0, 8'h01);
      chk_irq(1'b1, "R7 both enables and status give irq");
      wr(2'd1, 8'h02);
      chk_irq(1'b0, "R7 enabled source has no status");
      rd(2'd1, 8'h02, "R8 source enable readback");
      rd(2'd0, 8'h01, "R8 group enable readback");

      wr(2'd2, 8'h07);
      rd(2'd2, 8'h00, "R5 w1c clears all");
      evt = 3'b001;
      wr(2'd2, 8'h01);
      rd(2'd2, 8'h01, "R6 event beats w1c clear");
      wr(2'd2, 8'h01);

      wr(2'd3, 8'h01);
      rd(2'd3, 8'h01, "R8 mode readback");
      pulse(3'b011);
      chk_irq(1'b1, "R7 irq from end event");
      rd(2'd2, 8'h03, "R4 read returns status");
      chk_irq(1'b0, "R4 irq drops after clearing read");
      rd(2'd2, 8'h00, "R4 status cleared by read");

      pulse(3'b100);
      wr(2'd2, 8'h07);
      rd(2'd2, 8'h04, "R5 write ignored in clear-on-read mode");

      pulse(3'b001);
      evt = 3'b010;
      rd(2'd2, 8'h01, "R4 read returns value before same-cycle event");
      rd(2'd2, 8'h02, "R6 event survives clearing read");

      wr(2'd0, 8'h00);
      wr(2'd1, 8'h07);
      pulse(3'b111);
      chk_irq(1'b0, "R9 group off with all sources enabled");
      wr(2'd0, 8'h01);
      chk_irq(1'b1, "R7 irq once group enabled");

      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk_irq(1'b0, "R1 irq after second reset");
      rd(2'd2, 8'h00, "R1 status cleared by reset");
      rd(2'd3, 8'h00, "R1 mode back to w1c");

      repeat (2) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule